// File: doc/BRIEF.md
# Word Load/Store Address Unit with Base Writeback

This block forms the memory address for single-word load and store operations and decides whether the base register is rewritten. An operation names a base register, a data register and an offset source. The offset is either a zero-extended byte immediate, or the value of an index register shifted left by a small amount. One of three indexing modes is applied:
- plain offset, which leaves the base alone;
- pre-indexed, which accesses at base plus offset and then keeps that sum in the base register;
- post-indexed, which accesses at the untouched base and then writes base plus offset back.

A small register file and a small word RAM sit behind the address logic, so that operations can be checked end to end. The RAM occupies a window starting at byte address 0x40000000. Any access that is misaligned, or that falls outside the window, is refused. A refused operation does not touch memory and does not write any register.

Each operation completes in one clock. The address, the fault flag and the base update are valid combinationally while `op_valid` is high. Register and memory writes take effect at the rising edge. A configuration port preloads registers, and a peek port reads them.

Top module: `ldst_agen`

## Requirements
- R1: The offset is the 8-bit `op_imm` zero-extended when `op_use_idx` is 0. When `op_use_idx` is 1, the offset is the register named by `op_index` shifted left by `op_shift` (0 to 3). `base_next` always equals base plus offset.
- R2: With `op_mode` = 0 (offset), `mem_addr` is base plus offset, `base_we` stays low and the base register keeps its value.
- R3: With `op_mode` = 1 (pre-indexed), `mem_addr` is base plus offset and the base register holds that sum after the edge.
- R4: With `op_mode` = 2 (post-indexed), `mem_addr` is the unmodified base and the base register holds base plus offset after the edge.
- R5: `op_mode` = 3 behaves exactly like offset mode.
- R6: If `mem_addr` has either of its low two bits set, `addr_fault` is high, no memory word changes and no register is written.
- R7: If `mem_addr` lies below 0x40000000 or at or above 0x40000000 + 4*WORDS, `addr_fault` is high and the operation has no effect.
- R8: A load that does not fault writes the addressed word into the data register at the edge. If the data register is also the base register, the loaded word wins over the base update.
- R9: A store that does not fault writes to memory the value the data register held before the edge, even when the same register is updated as the base.
- R10: After reset every register and memory word reads zero, and with `op_valid` low both `addr_fault` and `base_we` are low.
- R11: A write on the configuration port is visible on `peek_data` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register preload strobe |
| cfg_idx | input | 4 | Register to preload |
| cfg_data | input | 32 | Preload value |
| peek_idx | input | 4 | Register to observe |
| peek_data | output | 32 | Value of the observed register |
| op_valid | input | 1 | Operation present this cycle |
| op_load | input | 1 | 1 = load, 0 = store |
| op_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 as offset |
| op_use_idx | input | 1 | Offset from index register instead of immediate |
| op_imm | input | 8 | Immediate byte offset |
| op_shift | input | 2 | Left shift applied to the index register |
| op_base | input | 4 | Base register number |
| op_index | input | 4 | Index register number |
| op_data | input | 4 | Load destination / store source register |
| mem_addr | output | 32 | Effective byte address |
| mem_rdata | output | 32 | Word at the effective address (zero outside the window) |
| base_we | output | 1 | Base writeback happens at this edge |
| base_next | output | 32 | Base plus offset |
| addr_fault | output | 1 | Misaligned or out-of-window access |

## Verification
The sweep crosses all four mode codes with loads and stores, and with both offset sources. Offsets of 0, 4, 12 and 1 separate an aligned address from a misaligned one. Shift amounts 0 to 3 show whether the index register is scaled before the add. Base values are chosen at the window start, inside it, at its last words, misaligned, and just below it, so that the two fault causes can be told apart from a valid access. Each case is run once with distinct data and base registers and once with them equal. This exposes the load-over-base priority and the store-of-old-value rule.

// File: rtl/ldst_agen.sv
module ldst_agen #(
  parameter int NREG = 16,
  parameter int WORDS = 16,
  parameter int IMMW = 8,
  parameter int SHW = 2,
  parameter logic [31:0] RAM_BASE = 32'h4000_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NREG)-1:0]   cfg_idx,
  input  logic [31:0]               cfg_data,
  input  logic [$clog2(NREG)-1:0]   peek_idx,
  output logic [31:0]               peek_data,
  input  logic                      op_valid,
  input  logic                      op_load,
  input  logic [1:0]                op_mode,
  input  logic                      op_use_idx,
  input  logic [IMMW-1:0]           op_imm,
  input  logic [SHW-1:0]            op_shift,
  input  logic [$clog2(NREG)-1:0]   op_base,
  input  logic [$clog2(NREG)-1:0]   op_index,
  input  logic [$clog2(NREG)-1:0]   op_data,
  output logic [31:0]               mem_addr,
  output logic [31:0]               mem_rdata,
  output logic                      base_we,
  output logic [31:0]               base_next,
  output logic                      addr_fault
);
  localparam int MW = $clog2(WORDS);
  localparam logic [31:0] WIN = 32'(WORDS * 4);

  logic [31:0] regs [NREG];
  logic [31:0] mem  [WORDS];

  logic [31:0] base, offset, rel;
  logic        in_win, is_post, writes_base, go;
  logic [MW-1:0] widx;

  assign base        = regs[op_base];
  assign offset      = op_use_idx ? 32'(regs[op_index] << op_shift)
                                  : {{(32-IMMW){1'b0}}, op_imm};
  assign base_next   = base + offset;
  assign is_post     = (op_mode == 2'd2);
  assign writes_base = (op_mode == 2'd1) || is_post;
  assign mem_addr    = is_post ? base : base_next;
  assign rel         = mem_addr - RAM_BASE;
  assign in_win      = (mem_addr >= RAM_BASE) && (rel < WIN);
  assign widx        = rel[MW+1:2];
  assign mem_rdata   = in_win ? mem[widx] : '0;
  assign addr_fault  = op_valid && ((mem_addr[1:0] != 2'b00) || !in_win);
  assign go          = op_valid && !addr_fault;
  assign base_we     = go && writes_base;
  assign peek_data   = regs[peek_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (cfg_we)          regs[cfg_idx] <= cfg_data;
      if (base_we)         regs[op_base] <= base_next;
      if (go && op_load)   regs[op_data] <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (go && !op_load) begin
      mem[widx] <= regs[op_data];
    end
  end
endmodule

// File: rtl/ldst_agen_chk.sv
module ldst_agen_chk #(
  parameter int NREG = 16,
  parameter int WORDS = 16,
  parameter logic [31:0] RAM_BASE = 32'h4000_0000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    op_valid,
  input logic                    op_load,
  input logic [1:0]              op_mode,
  input logic [$clog2(NREG)-1:0] op_base,
  input logic [$clog2(NREG)-1:0] op_data,
  input logic [31:0]             mem_addr,
  input logic [31:0]             mem_rdata,
  input logic                    base_we,
  input logic [31:0]             base_next,
  input logic                    addr_fault,
  input logic [$clog2(WORDS)-1:0] widx,
  input logic [31:0]             regs [NREG],
  input logic [31:0]             mem  [WORDS]
);
  a_r6_misalign_faults: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (mem_addr[1:0] != 2'b00) |-> addr_fault);

  a_r6_fault_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    addr_fault |-> !base_we);

  a_r7_below_window: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (mem_addr < RAM_BASE) |-> addr_fault);

  a_r2_offset_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_mode == 2'd0 || op_mode == 2'd3) |-> !base_we);

  a_r4_post_uses_base: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_mode == 2'd2 |-> mem_addr == regs[op_base]);

  a_r3_pre_addr_is_sum: assert property (@(posedge clk) disable iff (!rst_n)
    base_we && op_mode == 2'd1 |-> base_next == mem_addr);

  a_r3_base_updated: assert property (@(posedge clk) disable iff (!rst_n)
    base_we && !(op_load && op_data == op_base)
    |=> regs[$past(op_base)] == $past(base_next));

  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_load && !addr_fault && op_data == op_base
    |=> regs[$past(op_data)] == $past(mem_rdata));

  a_r9_store_old_value: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_load && !addr_fault
    |=> mem[$past(widx)] == $past(regs[op_data]));
endmodule

bind ldst_agen ldst_agen_chk #(.NREG(NREG), .WORDS(WORDS), .RAM_BASE(RAM_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_load(op_load),
  .op_mode(op_mode), .op_base(op_base), .op_data(op_data),
  .mem_addr(mem_addr), .mem_rdata(mem_rdata), .base_we(base_we),
  .base_next(base_next), .addr_fault(addr_fault), .widx(widx),
  .regs(regs), .mem(mem)
);

// File: tb/test_ldst_agen.sv
module test_ldst_agen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0, peek_idx = '0, op_base = '0, op_index = '0, op_data = '0;
  logic [31:0] cfg_data = '0;
  logic op_valid = 1'b0, op_load = 1'b0, op_use_idx = 1'b0;
  logic [1:0] op_mode = '0, op_shift = '0;
  logic [7:0] op_imm = '0;
  logic [31:0] peek_data, mem_addr, mem_rdata, base_next;
  logic base_we, addr_fault;

  int n_chk = 0, n_fail = 0;
  logic [31:0] regs_m [16];
  logic [31:0] mem_m [16];

  always #5 clk = ~clk;

  ldst_agen i_ldst_agen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .peek_idx(peek_idx), .peek_data(peek_data), .op_valid(op_valid), .op_load(op_load),
    .op_mode(op_mode), .op_use_idx(op_use_idx), .op_imm(op_imm), .op_shift(op_shift),
    .op_base(op_base), .op_index(op_index), .op_data(op_data), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .base_we(base_we), .base_next(base_next), .addr_fault(addr_fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
    regs_m[idx] = val;
  endtask

  task automatic peek_mem(input logic [31:0] addr, input logic [31:0] exp, input string tag);
    cfg(4'd4, addr);
    op_valid = 1'b0; op_base = 4'd4; op_mode = 2'd0; op_use_idx = 1'b0; op_imm = 8'd0;
    #1 chk(tag, mem_rdata, exp);
  endtask

  function automatic logic [31:0] pick_base(input int s);
    case (s)
      0: return 32'h4000_0000;
      1: return 32'h4000_0010;
      2: return 32'h4000_0038;
      3: return 32'h4000_0002;
      default: return 32'h3FFF_FFFC;
    endcase
  endfunction

  initial begin : watchdog
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n = 0;
    for (int i = 0; i < 16; i++) begin regs_m[i] = '0; mem_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    for (int i = 0; i < 4; i++) begin
      peek_idx = 4'(i); #1 chk("R10 reg zero", peek_data, 32'h0);
    end
    chk("R10 fault idle", {31'h0, addr_fault}, 32'h0);
    chk("R10 base_we idle", {31'h0, base_we}, 32'h0);
    peek_mem(32'h4000_003C, 32'h0, "R10 mem zero");
    // R11 preload and peek
    cfg(4'd7, 32'h1234_5678);
    peek_idx = 4'd7; #1 chk("R11 peek", peek_data, 32'h1234_5678);

    for (int m = 0; m < 4; m++)
    for (int ld = 0; ld < 2; ld++)
    for (int ui = 0; ui < 2; ui++)
    for (int bs = 0; bs < 5; bs++)
    for (int os = 0; os < 4; os++)
    for (int same = 0; same < 2; same++) begin
      logic [31:0] b, off, sum, ea, rel, ldv;
      logic flt, wbe, go;
      logic [3:0] rd;
      int w;
      string mt, ft;
      n++;
      b = pick_base(bs);
      rd = same ? 4'd1 : 4'd3;
      cfg(4'd1, b);
      cfg(4'd2, 32'(os == 3 ? 1 : os + 1));
      if (!same) cfg(4'd3, 32'hC0DE_0000 + 32'(n));
      off = ui ? (regs_m[2] << os) : (os == 0 ? 32'd0 : os == 1 ? 32'd4 : os == 2 ? 32'd12 : 32'd1);
      sum = b + off;
      ea  = (m == 2) ? b : sum;
      rel = ea - 32'h4000_0000;
      flt = (ea[1:0] != 2'b00) || (ea < 32'h4000_0000) || (rel >= 32'd64);
      go  = !flt;
      wbe = go && (m == 1 || m == 2);
      w   = int'(rel[5:2]);
      ldv = mem_m[w];
      mt = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
      ft = (ea[1:0] != 2'b00) ? "R6" : "R7";

      @(negedge clk);
      op_valid = 1'b1; op_load = ld[0]; op_mode = 2'(m); op_use_idx = ui[0];
      op_imm = off[7:0]; op_shift = 2'(os); op_base = 4'd1; op_index = 4'd2; op_data = rd;
      #1;
      chk({mt, " addr"}, mem_addr, ea);
      chk({ft, " fault"}, {31'h0, addr_fault}, {31'h0, flt});
      chk({mt, " base_we"}, {31'h0, base_we}, {31'h0, wbe});
      chk("R1 base_next", base_next, sum);
      @(negedge clk);
      op_valid = 1'b0;
      if (go && ld == 0) mem_m[w] = regs_m[rd];
      if (wbe) regs_m[1] = sum;
      if (go && ld == 1) regs_m[rd] = ldv;
      peek_idx = 4'd1; #1 chk(flt ? {ft, " base kept"} : (same && ld == 1 && go) ? "R8 load priority" : {mt, " base reg"}, peek_data, regs_m[1]);
      if (!same) begin
        peek_idx = 4'd3; #1 chk(ld ? "R8 load dest" : "R9 store src kept", peek_data, regs_m[3]);
      end
      if (ea[1:0] == 2'b00 && !flt) peek_mem(ea, mem_m[w], ld ? "R8 mem intact" : "R9 store data");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule